// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational datapath slice. It takes two operand words, a carry input, two serial fill bits and a four-bit operation select, and returns one result word and a carry output. Inside it sit three parallel circuits: an adder-based arithmetic circuit, a bitwise logic circuit and a single-position shifter. An output multiplexer picks one of their results.

The select code is split into two fields. The upper two bits, `sel_i[3:2]`, choose the circuit that drives the result. The lower two bits, `sel_i[1:0]`, choose the operation inside the arithmetic or logic circuit. The arithmetic circuit has one adder. Its second input is chosen per bit from B, the complement of B, all zeros or all ones. Combined with the carry input, this gives add, add with carry, subtract with borrow, subtract, increment, decrement and transfer. The word width is a parameter and defaults to 16 bits.

Top module: `alsu`

## Requirements
- R1: With `sel_i = 4'b0000`, `{carry_o, result_o}` equals A + B + `carry_i` computed to WIDTH+1 bits.
- R2: With `sel_i = 4'b0001`, `{carry_o, result_o}` equals A + ~B + `carry_i`. When `carry_i = 1` this is A − B, and `carry_o = 1` means no borrow occurred.
- R3: With `sel_i = 4'b0010`, `{carry_o, result_o}` equals A + `carry_i`, and B has no effect.
- R4: With `sel_i = 4'b0011`, `{carry_o, result_o}` equals A + all-ones + `carry_i`. When `carry_i = 0` the result is A − 1. When `carry_i = 1` the result is A, with `carry_o = 1`.
- R5: With `sel_i[3:2] = 2'b01`, `sel_i[1:0]` of 00, 01 and 10 give A AND B, A OR B and A XOR B respectively.
- R6: With `sel_i = 4'b0111`, the result is the bitwise complement of A, and B, `carry_i` and both fill bits have no effect.
- R7: With `sel_i[3:2] = 2'b10`, result bit i equals A bit i+1 for i < WIDTH−1, and the top result bit equals `fill_r_i`.
- R8: With `sel_i[3:2] = 2'b11`, result bit i equals A bit i−1 for i > 0, and result bit 0 equals `fill_l_i`.
- R9: `carry_o` is 0 whenever `sel_i[3:2]` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand; the only operand of the shift paths |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Adder carry input |
| fill_r_i | input | 1 | Bit shifted into the top position on a right shift |
| fill_l_i | input | 1 | Bit shifted into bit 0 on a left shift |
| sel_i | input | 4 | [3:2] choose the circuit, [1:0] choose the operation |
| result_o | output | WIDTH | Selected result word |
| carry_o | output | 1 | Adder carry in arithmetic mode, otherwise 0 |

## Verification
The assertions are evaluated each time the combinational outputs settle. They assume that every input holds a known 0 or 1 value, and they are skipped while any input is unknown. The stimulus drives all inputs to defined values from time zero and changes them only just after a clock edge, so the outputs have settled before they are sampled at the opposite edge. Operands include all-zero, all-one, sign-bit and alternating patterns. Each of these is tried with every select code, with both carry values and with both fill values, and seeded random words follow.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  localparam int unsigned SEL_W = 4;

  typedef enum logic [1:0] {
    MODE_ARITH = 2'b00,
    MODE_LOGIC = 2'b01,
    MODE_SHR   = 2'b10,
    MODE_SHL   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NB   = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
  import alsu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   c;

  assign c[0] = carry_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // per-bit 4:1 mux on the adder's second input
    always_comb begin
      unique case (ysel_e'(op_i))
        YSEL_B:    y[i] = b_i[i];
        YSEL_NB:   y[i] = ~b_i[i];
        YSEL_ZERO: y[i] = 1'b0;
        default:   y[i] = 1'b1;
      endcase
    end
    assign sum_o[i] = a_i[i] ^ y[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & y[i]) | (c[i] & (a_i[i] ^ y[i]));
  end

  assign carry_o = c[WIDTH];
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (lop_e'(op_i))
        LOP_AND: res_o[i] = a_i[i] & b_i[i];
        LOP_OR:  res_o[i] = a_i[i] | b_i[i];
        LOP_XOR: res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = ~a_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             fill_r_i,
  input  logic             fill_l_i,
  output logic [WIDTH-1:0] shr_o,
  output logic [WIDTH-1:0] shl_o
);
  localparam int unsigned MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign shr_o[i] = fill_r_i;
    end else begin : g_mid_r
      assign shr_o[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl_o[i] = fill_l_i;
    end else begin : g_mid_l
      assign shl_o[i] = a_i[i-1];
    end
  end
endmodule

// File: rtl/alsu.sv
module alsu
  import alsu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic             fill_r_i,
  input  logic             fill_l_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] arith_res, logic_res, shr_res, shl_res;
  logic             arith_co;
  mode_e            mode;

  assign mode = mode_e'(sel_i[3:2]);

  alsu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .op_i    (sel_i[1:0]),
    .sum_o   (arith_res),
    .carry_o (arith_co)
  );

  alsu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (sel_i[1:0]),
    .res_o (logic_res)
  );

  alsu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i      (a_i),
    .fill_r_i (fill_r_i),
    .fill_l_i (fill_l_i),
    .shr_o    (shr_res),
    .shl_o    (shl_res)
  );

  always_comb begin
    unique case (mode)
      MODE_ARITH: result_o = arith_res;
      MODE_LOGIC: result_o = logic_res;
      MODE_SHR:   result_o = shr_res;
      default:    result_o = shl_res;
    endcase
  end

  assign carry_o = (mode == MODE_ARITH) ? arith_co : 1'b0;
endmodule

// File: rtl/alsu_chk.sv
module alsu_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic             fill_r_i,
  input logic             fill_l_i,
  input logic [3:0]       sel_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic known;
  logic [WIDTH:0] a_ext, b_ext, c_ext;

  assign known = !$isunknown({a_i, b_i, carry_i, fill_r_i, fill_l_i, sel_i});
  assign a_ext = {1'b0, a_i};
  assign b_ext = {1'b0, b_i};
  assign c_ext = {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    if (known) begin
      if (sel_i == 4'b0000)
        AST_ADD_SUM: assert ({carry_o, result_o} == a_ext + b_ext + c_ext); // R1
      if (sel_i == 4'b0001 && carry_i)
        AST_SUB_SUM: assert (result_o == a_i - b_i && carry_o == (a_i >= b_i)); // R2
      if (sel_i == 4'b0010)
        AST_INC_PASS: assert ({carry_o, result_o} == a_ext + c_ext); // R3
      if (sel_i == 4'b0011 && carry_i)
        AST_XFER_A: assert (result_o == a_i && carry_o); // R4
      if (sel_i == 4'b0110)
        AST_XOR_BITS: assert (result_o == (a_i ^ b_i)); // R5
      if (sel_i == 4'b0111)
        AST_NOT_A: assert (result_o == ~a_i); // R6
      if (sel_i[3:2] == 2'b10)
        AST_SHR_FILL: assert (result_o[WIDTH-1] == fill_r_i && result_o[WIDTH-2:0] == a_i[WIDTH-1:1]); // R7
      if (sel_i[3:2] == 2'b11)
        AST_SHL_FILL: assert (result_o[0] == fill_l_i && result_o[WIDTH-1:1] == a_i[WIDTH-2:0]); // R8
      if (sel_i[3:2] != 2'b00)
        AST_NO_CARRY: assert (!carry_o); // R9
    end
  end
endmodule

bind alsu alsu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .carry_i  (carry_i),
  .fill_r_i (fill_r_i),
  .fill_l_i (fill_l_i),
  .sel_i    (sel_i),
  .result_o (result_o),
  .carry_o  (carry_o)
);

// File: tb/alsu_tb.sv
module alsu_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic         cin, fr, fl, co;
  logic [3:0]   sel;

  int total = 0;
  int bad = 0;

  alsu #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .carry_i(cin), .fill_r_i(fr), .fill_l_i(fl),
    .sel_i(sel), .result_o(res), .carry_o(co)
  );

  function automatic string req_of(logic [3:0] s);
    case (s[3:2])
      2'b00: case (s[1:0])
               2'b00: return "R1";
               2'b01: return "R2";
               2'b10: return "R3";
               default: return "R4";
             endcase
      2'b01: return (s[1:0] == 2'b11) ? "R6" : "R5";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  // behavioural reference built from integer arithmetic
  task automatic model(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic ic,
                       input logic ifr, input logic ifl, input logic [3:0] s,
                       output logic [W-1:0] er, output logic ec);
    longint unsigned sum;
    longint unsigned mask = (64'd1 << W) - 1;
    longint unsigned av = ia;
    longint unsigned bv = ib;
    er = '0;
    ec = 1'b0;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: sum = av + bv + ic;
          2'b01: sum = av + (mask - bv) + ic;
          2'b10: sum = av + ic;
          default: sum = av + mask + ic;
        endcase
        er = sum[W-1:0];
        ec = sum[W];
      end
      2'b01: case (s[1:0])
               2'b00: er = ia & ib;
               2'b01: er = ia | ib;
               2'b10: er = ia ^ ib;
               default: er = ~ia;
             endcase
      2'b10: er = W'((av / 2) + (longint'(ifr) << (W - 1)));
      default: er = W'(((av * 2) & mask) + ifl);
    endcase
  endtask

  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic ic,
                       input logic ifr, input logic ifl, input logic [3:0] s);
    logic [W-1:0] er;
    logic ec;
    @(posedge clk);
    #1;
    a = ia; b = ib; cin = ic; fr = ifr; fl = ifl; sel = s;
    model(ia, ib, ic, ifr, ifl, s, er, ec);
    @(negedge clk);
    total++;
    if (res !== er || co !== ec) begin
      bad++;
      $display("FAIL %s sel=%b a=%h b=%h cin=%0b: got %h/%0b exp %h/%0b",
               req_of(s), s, ia, ib, ic, res, co, er, ec);
    end
    if (s[3:2] != 2'b00) begin // R9
      total++;
      if (co !== 1'b0) begin
        bad++;
        $display("FAIL R9 sel=%b: carry got %0b exp 0", s, co);
      end
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] corners [7];
    corners = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF, 16'hAAAA, 16'h5555};
    a = '0; b = '0; cin = 1'b0; fr = 1'b0; fl = 1'b0; sel = 4'b0000;
    repeat (3) @(posedge clk);
    // reset-time state: all-zero inputs give zero result (R1)
    @(negedge clk);
    total++;
    if (res !== '0 || co !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle: got %h/%0b exp 0000/0", res, co);
    end
    rst_ni = 1'b1;

    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          for (int c = 0; c < 2; c++)
            apply(corners[i], corners[j], c[0], c[0], ~c[0], 4'(s));

    // R6: B, carry and fills must not move the complement result
    apply(16'h1234, 16'h0000, 1'b0, 1'b0, 1'b0, 4'b0111);
    apply(16'h1234, 16'hFFFF, 1'b1, 1'b1, 1'b1, 4'b0111);
    // R3: B ignored in increment/transfer
    apply(16'hFFFF, 16'h5A5A, 1'b1, 1'b0, 1'b0, 4'b0010);
    // R4: decrement of zero wraps with no carry
    apply(16'h0000, 16'h1111, 1'b0, 1'b0, 1'b0, 4'b0011);
    // R7, R8: fills land at the ends
    apply(16'h0001, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b1000);
    apply(16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'b1100);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1 = $urandom;
      logic [31:0] r2 = $urandom;
      apply(r1[W-1:0], r2[W-1:0], r2[31], r1[31], r1[30], r2[19:16]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule